// File: doc/BRIEF.md
# Pulse-Width Band Filter

This block sorts the level segments of a digital input by length and reports whether each one fell inside a programmed window. Two duration timers share one clock and one synchronised copy of the input. One timer holds the upper bound of the window and the other holds the lower bound. On every change of the synchronised input, both timers have just measured the same segment. The segment that ended is then judged against both bounds, and the two timers are restarted for the next segment.

Each timer has an 8-bit load value, given on active-low pins, and a 2-bit predivider code that sets the length of one timer tick. The upper timer's decision gates the lower timer's decision. The result is registered as the band output. The upper timer's own decision is also brought out for observation. Both outputs change only when a synchronised input edge occurs, and they hold their value between edges. Measuring starts again at every edge, so high and low segments are judged the same way.

Top module: `pdw_band_filter`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release, `band_o` and `long_o` are both 0.
- R2: With predivider code 0, `long_o` becomes 1 after a segment of D clock cycles when D <= L, and 0 when D > L. Here L is the upper load value.
- R3: With both predivider codes 0, `band_o` becomes 1 after a segment of D cycles exactly when S < D <= L, where S is the lower load value. Otherwise it becomes 0.
- R4: High segments and low segments are measured and judged by the same rule.
- R5: `band_o` and `long_o` keep their value in every cycle that does not follow a synchronised input edge.
- R6: A load value is the bitwise inverse of its preset pins. For example, pins 8'hF3 give a load of 12.
- R7: Predivider codes 0, 1, 2 and 3 scale a timer tick to 1, 16, 256 and 4096 clock cycles. With codes above 0, a threshold is exact to within one tick.
- R8: If L <= S and both codes are 0, `band_o` stays 0.
- R9: Both outputs take the verdict for a segment exactly 3 clock cycles after the input change that ends the segment: two cycles for the synchroniser and one for the output register.
- R10: The first input edge after reset ends no measured segment, and it drives both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sig_i | input | 1 | Asynchronous signal whose segments are measured |
| long_preset_n_i | input | 8 | Upper bound load, active low |
| long_div_i | input | 2 | Upper bound predivider code |
| short_preset_n_i | input | 8 | Lower bound load, active low |
| short_div_i | input | 2 | Lower bound predivider code |
| band_o | output | 1 | 1 when the last segment fell inside the window |
| long_o | output | 1 | 1 when the last segment did not exceed the upper bound |

## Verification
The bench uses the default parameters: an 8-bit load, a 2-stage synchroniser and 4-bit predivider steps. With these values, code 0 makes every threshold exact to one cycle. The bench can therefore test both sides of each bound (S, S+1, L, L+1) with segments only a few cycles long. One run sets code 1 on the upper timer, which gives 16-cycle ticks. It uses segments far from that bound so that the result does not depend on the tick phase. A third configuration uses an inverted window to show that the band output stays at 0.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
    localparam int CNT_W   = 8;
    localparam int SEL_W   = 2;
    localparam int STEP_W  = 4;
    localparam int SYNC_N  = 2;

    typedef struct packed {
        logic band;
        logic lng;
    } verdict_t;
endpackage

// File: rtl/pdw_sync.sv
module pdw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic raw_i,
    output logic edge_o
);
    typedef struct packed {
        logic [STAGES:0] sh;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[STAGES-1:0], raw_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign edge_o = st_q.sh[STAGES-1] ^ st_q.sh[STAGES];
endmodule

// File: rtl/pdw_prescale.sv
module pdw_prescale #(
    parameter int SEL_W  = 2,
    parameter int STEP_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int NCODE = 2 ** SEL_W;
    localparam int PRE_W = STEP_W * (NCODE - 1);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_st_t;

    pre_st_t          st_d, st_q;
    logic [NCODE-1:0] tick_opt;

    assign tick_opt[0] = 1'b1;
    for (genvar g = 1; g < NCODE; g++) begin : g_code
        assign tick_opt[g] = &st_q.cnt[STEP_W*g-1:0];
    end

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign tick_o = tick_opt[sel_i];
endmodule

// File: rtl/pdw_timer.sv
module pdw_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             edge_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] load_n_i,
    output logic             expired_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             expired;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (edge_i) begin
            st_d.cnt     = ~load_n_i;
            st_d.expired = 1'b0;
        end else if (tick_i && !st_q.expired) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt <= CNT_W'(1)) st_d.expired = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt     <= '0;
            st_q.expired <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign expired_o = st_q.expired;
endmodule

// File: rtl/pdw_band_filter.sv
module pdw_band_filter #(
    parameter int CNT_W  = pdw_pkg::CNT_W,
    parameter int SEL_W  = pdw_pkg::SEL_W,
    parameter int STEP_W = pdw_pkg::STEP_W,
    parameter int SYNC_N = pdw_pkg::SYNC_N
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sig_i,
    input  logic [CNT_W-1:0] long_preset_n_i,
    input  logic [SEL_W-1:0] long_div_i,
    input  logic [CNT_W-1:0] short_preset_n_i,
    input  logic [SEL_W-1:0] short_div_i,
    output logic             band_o,
    output logic             long_o
);
    import pdw_pkg::verdict_t;

    localparam int NT = 2;

    logic                  sig_edge;
    logic [NT-1:0]         tick_w;
    logic [NT-1:0]         exp_w;
    logic [NT-1:0][CNT_W-1:0] load_n_w;
    logic [NT-1:0][SEL_W-1:0] div_w;

    assign load_n_w = {short_preset_n_i, long_preset_n_i};
    assign div_w    = {short_div_i, long_div_i};

    pdw_sync #(.STAGES(SYNC_N)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .raw_i  (sig_i),
        .edge_o (sig_edge)
    );

    for (genvar t = 0; t < NT; t++) begin : g_tmr
        pdw_prescale #(.SEL_W(SEL_W), .STEP_W(STEP_W)) u_pre (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .sel_i  (div_w[t]),
            .tick_o (tick_w[t])
        );
        pdw_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .edge_i    (sig_edge),
            .tick_i    (tick_w[t]),
            .load_n_i  (load_n_w[t]),
            .expired_o (exp_w[t])
        );
    end

    verdict_t vd_d, vd_q;

    // index 0 = upper bound timer, index 1 = lower bound timer
    always_comb begin
        vd_d = vd_q;
        if (sig_edge) begin
            vd_d.lng  = ~exp_w[0];
            vd_d.band = ~exp_w[0] & exp_w[1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) vd_q <= '0;
        else         vd_q <= vd_d;
    end

    assign band_o = vd_q.band;
    assign long_o = vd_q.lng;
endmodule

// File: rtl/pdw_band_filter_chk.sv
module pdw_band_filter_chk #(
    parameter int CNT_W = 8,
    parameter int SEL_W = 2
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             sig_edge,
    input logic [CNT_W-1:0] long_preset_n_i,
    input logic [SEL_W-1:0] long_div_i,
    input logic [CNT_W-1:0] short_preset_n_i,
    input logic [SEL_W-1:0] short_div_i,
    input logic             band_o,
    input logic             long_o
);
    assert_reset_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (!band_o && !long_o));

    assert_hold_between_edges_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sig_edge |=> ($stable(band_o) && $stable(long_o)));

    assert_band_implies_long_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        band_o |-> long_o);

    assert_empty_window_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((~long_preset_n_i <= ~short_preset_n_i) && long_div_i == '0 && short_div_i == '0)
        |-> !band_o);
endmodule

bind pdw_band_filter pdw_band_filter_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .sig_edge         (sig_edge),
    .long_preset_n_i  (long_preset_n_i),
    .long_div_i       (long_div_i),
    .short_preset_n_i (short_preset_n_i),
    .short_div_i      (short_div_i),
    .band_o           (band_o),
    .long_o           (long_o)
);

// File: tb/pdw_band_filter_test.sv
module pdw_band_filter_test;
    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       sig_i = 1'b0;
    logic [7:0] long_preset_n_i = ~8'd12;
    logic [1:0] long_div_i = 2'd0;
    logic [7:0] short_preset_n_i = ~8'd5;
    logic [1:0] short_div_i = 2'd0;
    logic       band_o, long_o;

    always #2 clk_i = ~clk_i;

    pdw_band_filter uut (
        .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(sig_i),
        .long_preset_n_i(long_preset_n_i), .long_div_i(long_div_i),
        .short_preset_n_i(short_preset_n_i), .short_div_i(short_div_i),
        .band_o(band_o), .long_o(long_o)
    );

    typedef struct {
        int    due;
        bit    band;
        bit    lng;
        string tag;
    } item_t;

    item_t q[$];
    int  cyc = 0;
    int  errors = 0;
    int  checks = 0;
    bit  mon_on = 1'b0;
    bit  cur_band = 1'b0;
    bit  cur_lng = 1'b0;
    bit  done = 1'b0;

    always @(posedge clk_i) cyc <= cyc + 1;

    task automatic check(bit act_b, bit act_l, bit eb, bit el, string tag);
        checks++;
        if (act_b !== eb || act_l !== el) begin
            errors++;
            $display("FAIL %s cyc=%0d band=%0b long=%0b expected band=%0b long=%0b",
                     tag, cyc, act_b, act_l, eb, el);
        end
    endtask

    // monitor: pops due items, otherwise checks that outputs hold (R5)
    always @(negedge clk_i) begin
        if (mon_on) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                item_t it;
                it = q.pop_front();
                cur_band = it.band;
                cur_lng  = it.lng;
                check(band_o, long_o, cur_band, cur_lng, it.tag);
            end else begin
                check(band_o, long_o, cur_band, cur_lng, "R5 hold");
            end
        end
    end

    // driver: wait d cycles, toggle the input, push the verdict due 3 cycles later (R9)
    task automatic seg(int d, bit eb, bit el, string tag);
        item_t it;
        repeat (d) @(negedge clk_i);
        sig_i = ~sig_i;
        it.due = cyc + 3;
        it.band = eb;
        it.lng = el;
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic do_reset(logic [7:0] lp, logic [1:0] ld, logic [7:0] sp, logic [1:0] sd);
        @(negedge clk_i);
        mon_on = 1'b0;
        while (q.size() > 0) void'(q.pop_front());
        rst_ni = 1'b0;
        long_preset_n_i = lp;
        long_div_i = ld;
        short_preset_n_i = sp;
        short_div_i = sd;
        repeat (3) @(negedge clk_i);
        check(band_o, long_o, 1'b0, 1'b0, "R1 in reset");
        rst_ni = 1'b1;
        cur_band = 1'b0;
        cur_lng = 1'b0;
        mon_on = 1'b1;
    endtask

    initial begin
        // phase A: window 5 < D <= 12, both undivided (R6: pins are inverted loads)
        do_reset(8'hF3, 2'd0, ~8'd5, 2'd0);
        seg(10, 0, 0, "R10");
        seg(8,  1, 1, "R3 R9");
        seg(3,  0, 1, "R2");
        seg(5,  0, 1, "R3 lower bound");
        seg(6,  1, 1, "R3 lower bound+1");
        seg(12, 1, 1, "R6 upper bound");
        seg(13, 0, 0, "R2 upper bound+1");
        seg(40, 0, 0, "R5 long segment");
        seg(9,  1, 1, "R4 high/low alike");
        seg(7,  1, 1, "R4");
        repeat (6) @(negedge clk_i);

        // phase B: upper timer with 16-cycle ticks, load 4
        do_reset(~8'd4, 2'd1, ~8'd5, 2'd0);
        seg(10,  0, 0, "R10");
        seg(30,  1, 1, "R7 inside scaled bound");
        seg(100, 0, 0, "R7 beyond scaled bound");
        seg(30,  1, 1, "R7");
        repeat (6) @(negedge clk_i);

        // phase C: inverted window L=4, S=6
        do_reset(~8'd4, 2'd0, ~8'd6, 2'd0);
        seg(10, 0, 0, "R10");
        seg(3,  0, 1, "R8");
        seg(5,  0, 0, "R8");
        seg(7,  0, 0, "R8");
        seg(4,  0, 1, "R8");
        repeat (6) @(negedge clk_i);

        mon_on = 1'b0;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule